// File: doc/BRIEF.md
# Three-Channel Tone and Noise Level Mixer

This block turns a set of sound-generator register fields into three 4-bit amplitude codes, one per voice. Each voice has a 12-bit period divider that flips a square wave. One 17-bit linear-feedback noise source, paced by a 5-bit period, is shared by all three voices. A six-bit active-low mask selects tone and/or noise for each voice. The gated level then passes either a fixed amplitude or a shared envelope level to that voice's output.

The block is clocked by the system clock and advanced by a single prescaler enable (`tickEn`), which pulses once per input-clock period of the sound generator (nominally 1 MHz). An internal divide-by-8 paces the tone dividers, and a further divide-by-2 paces the noise divider. Digital-to-analog conversion and stereo summing happen downstream.

Top module: `triVoiceMixer`

## Requirements
- R1: Voice i's tone square wave flips after every 8*N enabled ticks, where N is `tonePeriod[i]` and N=0 counts as 1. The first flip occurs on the 8*N-th enabled tick after reset, so the full period is 16*N ticks.
- R2: The noise state advances once every 16*N enabled ticks, where N is `noisePeriod` and N=0 counts as 1. The first advance occurs on the 16*N-th enabled tick after reset.
- R3: On each noise advance, the noise level is XORed with shift-register bit 0. Then a new bit, equal to bit 0 XOR bit 3, enters at bit 16 while the register shifts right by one. The register resets to 1 and the noise level resets to 0.
- R4: `mixMask` bit i (i=0,1,2 for voice 0,1,2) disables tone on voice i, and bit 3+i disables noise on voice i. A 1 means disabled.
- R5: With tone and noise both enabled, a voice's level is tone AND noise. With both disabled, the level is constantly high. With one enabled, the level follows that source.
- R6: If `ampReg[i]` bit 4 is 1, voice i's amplitude is `envLevel`. Otherwise it is `ampReg[i]` bits 3:0.
- R7: `ampOut[i]` is 0 when voice i's level is low and its selected amplitude when the level is high. The output is registered, so it reflects the level and inputs present one clock earlier.
- R8: While `tickEn` is low, no divider, tone level, noise level or shift-register state changes.
- R9: While reset is asserted, every `ampOut` is 0 and the tone and noise levels are 0.
- R10: If a period is lowered below the divider's current count, the divider wraps and the wave flips on the very next divider step, instead of counting up to overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Prescaler enable, one pulse per sound-generator input clock |
| tonePeriod | input | 3x12 | Tone period per voice, index 0..2 |
| noisePeriod | input | 5 | Shared noise period |
| mixMask | input | 6 | Bits 2:0 tone off per voice, bits 5:3 noise off per voice |
| ampReg | input | 3x5 | Per-voice amplitude: bit 4 selects envelope, bits 3:0 fixed level |
| envLevel | input | 4 | Envelope level shared by all voices |
| ampOut | output | 3x4 | Registered amplitude code per voice |

## Verification
The bench predicts every output sample arithmetically from the count of enabled ticks. It then compares all three voices on every clock over several mask layouts: tone only, noise only, both sources ANDed, both sources off, and a different mix on each voice. Periods of 0 and 1 separate the "zero acts as one" rule from an off-by-one divider. Running the same set of voices with continuous, two-in-three and long-gap enable patterns shows whether state advances only on enabled ticks. A dedicated run lowers a period while the divider count is high, which distinguishes a wrap on the next step from a count that runs on to overflow.

// File: rtl/triVoicePkg.sv
`timescale 1ns/1ps
package triVoicePkg;
  // Strobes from the timing control to the datapath
  typedef struct packed {
    logic toneStep;   // advance every tone divider
    logic noiseStep;  // advance the noise divider
  } stepCtl_t;
endpackage

// File: rtl/triVoiceCtrl.sv
`timescale 1ns/1ps
module triVoiceCtrl
  import triVoicePkg::*;
#(
  parameter int PRE_DIV     = 8,
  parameter int NOISE_RATIO = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     tickEn,
  output stepCtl_t stepCtl
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam int RAT_W = (NOISE_RATIO > 1) ? $clog2(NOISE_RATIO) : 1;

  logic [PRE_W-1:0] preCnt;
  logic [RAT_W-1:0] ratCnt;
  logic             preWrap;
  logic             ratWrap;

  assign preWrap = (preCnt == PRE_W'(PRE_DIV - 1));
  assign ratWrap = (ratCnt == RAT_W'(NOISE_RATIO - 1));

  always_comb begin
    stepCtl.toneStep  = tickEn && preWrap;
    stepCtl.noiseStep = tickEn && preWrap && ratWrap;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      ratCnt <= '0;
    end else if (tickEn) begin
      preCnt <= preWrap ? '0 : preCnt + PRE_W'(1);
      if (preWrap) begin
        ratCnt <= ratWrap ? '0 : ratCnt + RAT_W'(1);
      end
    end
  end
endmodule

// File: rtl/triVoiceDivider.sv
`timescale 1ns/1ps
module triVoiceDivider #(
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             step,
  input  logic [PER_W-1:0] period,
  output logic             hit
);
  logic [PER_W-1:0] cnt;
  logic [PER_W-1:0] effPer;
  logic [PER_W:0]   cntInc;
  logic             wrap;

  assign effPer = (period == '0) ? PER_W'(1) : period;
  assign cntInc = {1'b0, cnt} + (PER_W + 1)'(1);
  // ">=" so a period lowered under the count wraps at once
  assign wrap   = (cntInc >= {1'b0, effPer});
  assign hit    = step && wrap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= wrap ? '0 : cntInc[PER_W-1:0];
    end
  end
endmodule

// File: rtl/triVoiceData.sv
`timescale 1ns/1ps
module triVoiceData
  import triVoicePkg::*;
#(
  parameter int NUM_CH  = 3,
  parameter int TONE_W  = 12,
  parameter int NOISE_W = 5,
  parameter int AMP_W   = 4,
  parameter int SR_W    = 17,
  parameter int SR_TAP  = 3,
  parameter int SR_SEED = 1
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  stepCtl_t                            stepCtl,
  input  logic [NUM_CH-1:0][TONE_W-1:0]       tonePeriod,
  input  logic [NOISE_W-1:0]                  noisePeriod,
  input  logic [2*NUM_CH-1:0]                 mixMask,
  input  logic [NUM_CH-1:0][AMP_W:0]          ampReg,
  input  logic [AMP_W-1:0]                    envLevel,
  output logic [NUM_CH-1:0]                   toneLvl,
  output logic                                noiseLvl,
  output logic [SR_W-1:0]                     lfsrState,
  output logic [NUM_CH-1:0][AMP_W-1:0]        ampOut
);
  logic [NUM_CH-1:0] toneHit;
  logic              noiseHit;

  // Tone dividers, one per voice
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gTone
    triVoiceDivider #(.PER_W(TONE_W)) u_div (
      .clk    (clk),
      .rstN   (rstN),
      .step   (stepCtl.toneStep),
      .period (tonePeriod[ch]),
      .hit    (toneHit[ch])
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            toneLvl[ch] <= 1'b0;
      else if (toneHit[ch]) toneLvl[ch] <= ~toneLvl[ch];
    end
  end

  // Shared noise source
  triVoiceDivider #(.PER_W(NOISE_W)) u_noiseDiv (
    .clk    (clk),
    .rstN   (rstN),
    .step   (stepCtl.noiseStep),
    .period (noisePeriod),
    .hit    (noiseHit)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsrState <= SR_W'(SR_SEED);
      noiseLvl  <= 1'b0;
    end else if (noiseHit) begin
      noiseLvl  <= noiseLvl ^ lfsrState[0];
      lfsrState <= {lfsrState[0] ^ lfsrState[SR_TAP], lfsrState[SR_W-1:1]};
    end
  end

  // Mixer and amplitude gate, one per voice
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gMix
    logic             mixLvl;
    logic [AMP_W-1:0] ampSel;

    always_comb begin
      mixLvl = (toneLvl[ch] | mixMask[ch]) & (noiseLvl | mixMask[NUM_CH + ch]);
      ampSel = ampReg[ch][AMP_W] ? envLevel : ampReg[ch][AMP_W-1:0];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) ampOut[ch] <= '0;
      else       ampOut[ch] <= mixLvl ? ampSel : '0;
    end
  end
endmodule

// File: rtl/triVoiceMixer.sv
`timescale 1ns/1ps
module triVoiceMixer
  import triVoicePkg::*;
#(
  parameter int NUM_CH      = 3,
  parameter int TONE_W      = 12,
  parameter int NOISE_W     = 5,
  parameter int AMP_W       = 4,
  parameter int SR_W        = 17,
  parameter int PRE_DIV     = 8,
  parameter int NOISE_RATIO = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          tickEn,
  input  logic [NUM_CH-1:0][TONE_W-1:0] tonePeriod,
  input  logic [NOISE_W-1:0]            noisePeriod,
  input  logic [2*NUM_CH-1:0]           mixMask,
  input  logic [NUM_CH-1:0][AMP_W:0]    ampReg,
  input  logic [AMP_W-1:0]              envLevel,
  output logic [NUM_CH-1:0][AMP_W-1:0]  ampOut
);
  stepCtl_t          stepCtl;
  logic [NUM_CH-1:0] toneLvl;
  logic              noiseLvl;
  logic [SR_W-1:0]   lfsrState;

  triVoiceCtrl #(
    .PRE_DIV     (PRE_DIV),
    .NOISE_RATIO (NOISE_RATIO)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tickEn  (tickEn),
    .stepCtl (stepCtl)
  );

  triVoiceData #(
    .NUM_CH  (NUM_CH),
    .TONE_W  (TONE_W),
    .NOISE_W (NOISE_W),
    .AMP_W   (AMP_W),
    .SR_W    (SR_W)
  ) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .stepCtl     (stepCtl),
    .tonePeriod  (tonePeriod),
    .noisePeriod (noisePeriod),
    .mixMask     (mixMask),
    .ampReg      (ampReg),
    .envLevel    (envLevel),
    .toneLvl     (toneLvl),
    .noiseLvl    (noiseLvl),
    .lfsrState   (lfsrState),
    .ampOut      (ampOut)
  );
endmodule

// File: rtl/triVoiceMixerChk.sv
`timescale 1ns/1ps
module triVoiceMixerChk
  import triVoicePkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int AMP_W  = 4,
  parameter int SR_W   = 17
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         tickEn,
  input stepCtl_t                     stepCtl,
  input logic [NUM_CH-1:0]            toneLvl,
  input logic                         noiseLvl,
  input logic [SR_W-1:0]              lfsrState,
  input logic [2*NUM_CH-1:0]          mixMask,
  input logic [NUM_CH-1:0][AMP_W-1:0] ampOut
);
  AST_STEP_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |-> !(stepCtl.toneStep || stepCtl.noiseStep)); // R8

  AST_NOISE_SUBSET: assert property (@(posedge clk) disable iff (!rstN)
    stepCtl.noiseStep |-> stepCtl.toneStep); // R2

  AST_TONE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stepCtl.toneStep |=> $stable(toneLvl)); // R1

  AST_NOISE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stepCtl.noiseStep |=> ($stable(lfsrState) && $stable(noiseLvl))); // R2

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    lfsrState != '0); // R3

  AST_NOISE_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    $changed(noiseLvl) |-> $past(lfsrState[0])); // R3

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChk
    AST_LOW_SILENT: assert property (@(posedge clk) disable iff (!rstN)
      (((toneLvl[ch] | mixMask[ch]) & (noiseLvl | mixMask[NUM_CH + ch])) == 1'b0)
      |=> (ampOut[ch] == '0)); // R7
  end
endmodule

bind triVoiceMixer triVoiceMixerChk #(
  .NUM_CH (NUM_CH),
  .AMP_W  (AMP_W),
  .SR_W   (SR_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .tickEn    (tickEn),
  .stepCtl   (stepCtl),
  .toneLvl   (toneLvl),
  .noiseLvl  (noiseLvl),
  .lfsrState (lfsrState),
  .mixMask   (mixMask),
  .ampOut    (ampOut)
);

// File: tb/triVoiceMixer_tb.sv
`timescale 1ns/1ps
module triVoiceMixer_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                 rstN = 1'b0;
  logic                 tickEn = 1'b0;
  logic [2:0][11:0]     tonePeriod = '0;
  logic [4:0]           noisePeriod = '0;
  logic [5:0]           mixMask = '1;
  logic [2:0][4:0]      ampReg = '0;
  logic [3:0]           envLevel = '0;
  logic [2:0][3:0]      ampOut;

  int checks = 0;
  int fails  = 0;
  int enCnt  = 0;
  bit finished = 0;
  bit nzLvl [64];

  triVoiceMixer u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .tonePeriod(tonePeriod),
    .noisePeriod(noisePeriod), .mixMask(mixMask), .ampReg(ampReg),
    .envLevel(envLevel), .ampOut(ampOut)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (tick %0d)", req, act, exp, enCnt);
    end
  endtask

  // Expected output after c enabled ticks of state (R1..R7)
  function automatic int expAmp(int ch, int c);
    int nt = (tonePeriod[ch] == 0) ? 1 : int'(tonePeriod[ch]);
    int nn = (noisePeriod == 0) ? 1 : int'(noisePeriod);
    bit t  = ((c / (8 * nt)) % 2) == 1;
    int u  = c / (16 * nn);
    bit n  = (u < 64) ? nzLvl[u] : 1'b0;
    bit lv = (t | mixMask[ch]) & (n | mixMask[3 + ch]);
    int a  = ampReg[ch][4] ? int'(envLevel) : int'(ampReg[ch][3:0]);
    return lv ? a : 0;
  endfunction

  task automatic stepClk(bit en);
    tickEn = en;
    @(posedge clk);
    if (en) enCnt++;
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    tickEn = 1'b0;
    repeat (3) @(negedge clk);
    for (int ch = 0; ch < 3; ch++) check("R9 reset output", int'(ampOut[ch]), 0);
    rstN = 1'b1;
    enCnt = 0;
  endtask

  task automatic runCfg(int t0, int t1, int t2, int nn, logic [5:0] mask,
                        logic [4:0] a0, logic [4:0] a1, logic [4:0] a2,
                        logic [3:0] env, int pat, string tag);
    int e [3];
    tonePeriod[0] = 12'(t0); tonePeriod[1] = 12'(t1); tonePeriod[2] = 12'(t2);
    noisePeriod = 5'(nn); mixMask = mask;
    ampReg[0] = a0; ampReg[1] = a1; ampReg[2] = a2; envLevel = env;
    doReset();
    for (int cyc = 0; cyc < 640; cyc++) begin
      bit en;
      if (pat == 0)      en = 1'b1;
      else if (pat == 1) en = (cyc % 3) != 0;
      else               en = !(cyc >= 100 && cyc < 220);
      for (int ch = 0; ch < 3; ch++) e[ch] = expAmp(ch, enCnt);
      stepClk(en);
      for (int ch = 0; ch < 3; ch++) check(tag, int'(ampOut[ch]), e[ch]);
    end
  endtask

  initial begin
    // Noise level sequence from the R3 recurrence
    logic [16:0] sr = 17'd1;
    bit lvl = 1'b0;
    nzLvl[0] = 1'b0;
    for (int k = 1; k < 64; k++) begin
      lvl = lvl ^ sr[0];
      sr  = {sr[0] ^ sr[3], sr[16:1]};
      nzLvl[k] = lvl;
    end

    @(negedge clk);
    runCfg(0, 1, 2, 1, 6'b111000, 5'd15, 5'd9, 5'd5, 4'd0, 0, "R1 R4 R7 tone only");
    runCfg(3, 4, 5, 0, 6'b000111, 5'd15, 5'd15, 5'd15, 4'd0, 0, "R2 R3 R4 noise only");
    runCfg(3, 4, 5, 3, 6'b000111, 5'd1, 5'd2, 5'd3, 4'd0, 0, "R2 R3 noise period 3");
    runCfg(1, 2, 3, 1, 6'b000000, 5'd10, 5'd11, 5'd12, 4'd0, 0, "R5 tone AND noise");
    runCfg(1, 2, 3, 1, 6'b111111, 5'h10, 5'd0, 5'd15, 4'd9, 0, "R5 R6 both off constant");
    runCfg(2, 3, 1, 1, 6'b001010, 5'h10, 5'h1F, 5'd3, 4'd12, 0, "R4 R5 R6 mixed voices");
    runCfg(7, 31, 2, 2, 6'b100001, 5'd0, 5'h14, 5'd8, 4'd6, 0, "R4 R6 R7 varied");
    runCfg(1, 2, 3, 1, 6'b000000, 5'd10, 5'd11, 5'd12, 4'd0, 1, "R8 gated two of three");
    runCfg(2, 1, 4, 2, 6'b010100, 5'h10, 5'd7, 5'd13, 4'd5, 2, "R8 long idle gap");

    // R10: lower the period while the divider count is high
    tonePeriod[0] = 12'd20; tonePeriod[1] = '0; tonePeriod[2] = '0;
    noisePeriod = 5'd1; mixMask = 6'b111110;
    ampReg[0] = 5'd15; ampReg[1] = 5'd0; ampReg[2] = 5'd0; envLevel = '0;
    doReset();
    repeat (120) stepClk(1'b1);
    check("R10 before lowering", int'(ampOut[0]), 0);
    tonePeriod[0] = 12'd3;
    while (enCnt < 154) begin
      stepClk(1'b1);
      if (enCnt == 128) check("R10 no flip yet", int'(ampOut[0]), 0);
      if (enCnt == 129) check("R10 wrap flips high", int'(ampOut[0]), 15);
      if (enCnt == 152) check("R10 new period high", int'(ampOut[0]), 15);
      if (enCnt == 153) check("R10 new period low", int'(ampOut[0]), 0);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #3000000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule